// File: doc/BRIEF.md
# PWM Carrier Trigger Generator

This block runs a triangular carrier counter and derives from it up to `N_CH` single-cycle trigger pulses, typically used to start a conversion at a fixed point of a PWM period. The carrier rises from 1 to a programmable period value and falls back to 1, over and over. Each channel owns a compare value and a 3-bit mode. The mode selects which carrier event fires the channel: a compare match on the rising slope, on the falling slope or on both, the carrier peak, the carrier bottom, or both of those.

Each compare value is held twice. Software writes the first copy, and matching uses the second copy. The channel mode also decides when the first copy is moved into the second. The slope-match modes move it only at the carrier peak and/or bottom, so a new value cannot take effect halfway through a slope. All other modes move it at once. A per-channel bypass bit forces an immediate move in any mode.

All configuration goes through a simple word-wide write port, with a combinational read port beside it.

Top module: `pwm_trig_gen`

## Requirements
- R1: With the run bit (address 0, bit 0) set, the counter starts at 1 and steps by one each clock. It rises to the period value (address 1), then falls to 1, and repeats, so one carrier cycle is 2·period−2 clocks. While the run bit is clear, the counter holds at 1.
- R2: A counter value reached by an upward step, including the peak, counts as up-counting. A value reached by a downward step, including the bottom, counts as down-counting. The first cycle after enabling counts as up-counting.
- R3: Mode 3'b001 fires when the counter equals the active compare value while down-counting. Mode 3'b010 fires on a match while up-counting. Mode 3'b011 fires on a match in either direction.
- R4: Mode 3'b100 fires when the counter equals the period (peak). Mode 3'b101 fires when the counter equals 1 (bottom). Mode 3'b110 fires at either point. Modes 3'b000 and 3'b111 never fire.
- R5: A trigger is high for exactly the clock cycle in which its qualifying counter value occurs. No trigger is produced while stopped, or in the first cycle after the run bit is set. In particular, a compare value of 1 does not fire in that first cycle.
- R6: A compare write (channel i at address 2+N_CH+i, bits [CNT_W-1:0]) lands in the write copy. Reading that address returns the last value written, whatever the active copy holds.
- R7: With the channel's bypass bit set (config address 2+i, bit 3), a compare write becomes active in the next cycle.
- R8: Without bypass, the active copy takes the write copy as follows: in mode 001, at each cycle with the counter equal to the period; in mode 010, at each cycle with the counter equal to 1; in mode 011, at either point. In every other mode it takes the write copy every cycle.
- R9: If a compare write and a scheduled transfer fall in the same cycle, the newly written value becomes active.
- R10: A write whose byte enables are not all set changes no register.
- R11: After reset, the run bit, all modes, bypass bits and compare values are 0, and the period reads its default (100). The channel mode sits in config bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Write address |
| wr_data | input | DATA_W (16) | Write data |
| wr_be | input | DATA_W/8 (2) | Byte enables; all must be set |
| rd_addr | input | ADDR_W (3) | Read address |
| rd_data | output | DATA_W (16) | Read data, combinational |
| trig_o | output | N_CH (2) | Per-channel trigger pulses |

## Verification
The assertions watch properties that hold on every cycle:
- the counter holds while stopped and moves by exactly one while running;
- no pulse appears while stopped or in the first running cycle;
- peak, bottom and slope-match pulses coincide with the right counter value and direction;
- bypassed writes arrive one cycle later;
- partial writes leave the write copy untouched;
- a slope-match compare stays frozen between its transfer points.

The exact cycle on which each channel fires across several carrier periods can only be shown by the bench's scenarios. The same holds for the delay of a new compare value until the next peak or bottom, and for the write that wins when it coincides with a transfer. These scenarios are compared against a timeline computed from the ramp definition.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

   typedef enum logic [2:0] {
      TM_OFF    = 3'b000,
      TM_DOWN   = 3'b001,
      TM_UP     = 3'b010,
      TM_BOTH   = 3'b011,
      TM_PEAK   = 3'b100,
      TM_VALLEY = 3'b101,
      TM_EDGES  = 3'b110,
      TM_OFF2   = 3'b111
   } trig_mode_e;

   typedef struct packed {
      logic       bypass;
      trig_mode_e mode;
   } chan_cfg_t;

   localparam int unsigned ADDR_CTRL   = 0;
   localparam int unsigned ADDR_PERIOD = 1;
   localparam int unsigned ADDR_CFG0   = 2;

   function automatic logic mode_is_sched(trig_mode_e m);
      return (m == TM_DOWN) || (m == TM_UP) || (m == TM_BOTH);
   endfunction

endpackage

// File: rtl/ptg_regs.sv
module ptg_regs
   import ptg_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int CNT_W      = 16,
   parameter int N_CH       = 2,
   parameter int ADDR_W     = 3,
   parameter int DEF_PERIOD = 100
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic [DATA_W/8-1:0]             wr_be,
   input  logic [ADDR_W-1:0]               rd_addr,
   output logic [DATA_W-1:0]               rd_data,
   output logic                            run_o,
   output logic [CNT_W-1:0]                period_o,
   output chan_cfg_t [N_CH-1:0]            cfg_o,
   output logic [N_CH-1:0][CNT_W-1:0]      cmp_wr_o,
   output logic [N_CH-1:0]                 cmp_we_o,
   output logic [CNT_W-1:0]                cmp_wdata_o
);

   localparam int CMP_BASE = ADDR_CFG0 + N_CH;
   localparam int CFG_W    = $bits(chan_cfg_t);

   logic wr_ok;
   assign wr_ok       = wr_en && (&wr_be);
   assign cmp_wdata_o = wr_data[CNT_W-1:0];

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
      return int'(a) == idx;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o    <= 1'b0;
         period_o <= CNT_W'(DEF_PERIOD);
      end else if (wr_ok) begin
         if (hit(wr_addr, ADDR_CTRL))   run_o    <= wr_data[0];
         if (hit(wr_addr, ADDR_PERIOD)) period_o <= wr_data[CNT_W-1:0];
      end
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      assign cmp_we_o[i] = wr_ok && hit(wr_addr, CMP_BASE + i);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_o[i]    <= '0;
            cmp_wr_o[i] <= '0;
         end else begin
            if (wr_ok && hit(wr_addr, ADDR_CFG0 + i))
               cfg_o[i] <= chan_cfg_t'(wr_data[CFG_W-1:0]);
            if (cmp_we_o[i])
               cmp_wr_o[i] <= wr_data[CNT_W-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (hit(rd_addr, ADDR_CTRL))   rd_data[0]         = run_o;
      if (hit(rd_addr, ADDR_PERIOD)) rd_data[CNT_W-1:0] = period_o;
      for (int i = 0; i < N_CH; i++) begin
         if (hit(rd_addr, ADDR_CFG0 + i)) rd_data[CFG_W-1:0] = cfg_o[i];
         if (hit(rd_addr, CMP_BASE + i))  rd_data[CNT_W-1:0] = cmp_wr_o[i];
      end
   end

endmodule

// File: rtl/ptg_carrier.sv
module ptg_carrier #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             up_o,
   output logic             first_o,
   output logic             peak_o,
   output logic             bottom_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_w
      $error("ptg_carrier: CNT_W must be at least 2");
   end

   logic going_up;
   assign going_up = up_o ? (cnt_o < period_i) : (cnt_o <= ONE);
   assign peak_o   = (cnt_o == period_i);
   assign bottom_o = (cnt_o == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o   <= ONE;
         up_o    <= 1'b1;
         first_o <= 1'b1;
      end else if (!run_i) begin
         cnt_o   <= ONE;
         up_o    <= 1'b1;
         first_o <= 1'b1;
      end else begin
         first_o <= 1'b0;
         up_o    <= going_up;
         cnt_o   <= going_up ? cnt_o + ONE : cnt_o - ONE;
      end
   end

endmodule

// File: rtl/ptg_channel.sv
module ptg_channel
   import ptg_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chan_cfg_t        cfg_i,
   input  logic             cmp_we_i,
   input  logic [CNT_W-1:0] cmp_wdata_i,
   input  logic [CNT_W-1:0] cmp_buf_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             up_i,
   input  logic             active_i,
   input  logic             peak_i,
   input  logic             bottom_i,
   output logic [CNT_W-1:0] cmp_act_o,
   output logic             trig_o
);

   logic             sched;
   logic             evt;
   logic             match;
   logic             fire;
   logic [CNT_W-1:0] nxt_val;

   always_comb begin
      sched = mode_is_sched(cfg_i.mode) && !cfg_i.bypass;
      unique case (cfg_i.mode)
         TM_DOWN: evt = peak_i;
         TM_UP:   evt = bottom_i;
         TM_BOTH: evt = peak_i || bottom_i;
         default: evt = 1'b0;
      endcase
   end

   assign nxt_val = cmp_we_i ? cmp_wdata_i : cmp_buf_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cmp_act_o <= '0;
      else if (!sched || evt)
         cmp_act_o <= nxt_val;
   end

   assign match = (cnt_i == cmp_act_o);

   always_comb begin
      unique case (cfg_i.mode)
         TM_DOWN:   fire = match && !up_i;
         TM_UP:     fire = match && up_i;
         TM_BOTH:   fire = match;
         TM_PEAK:   fire = peak_i;
         TM_VALLEY: fire = bottom_i;
         TM_EDGES:  fire = peak_i || bottom_i;
         default:   fire = 1'b0;
      endcase
   end

   assign trig_o = active_i && fire;

endmodule

// File: rtl/pwm_trig_gen.sv
module pwm_trig_gen
   import ptg_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int CNT_W      = 16,
   parameter int N_CH       = 2,
   parameter int ADDR_W     = 3,
   parameter int DEF_PERIOD = 100
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [DATA_W/8-1:0] wr_be,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   output logic [N_CH-1:0]     trig_o
);

   localparam int N_REGS = ADDR_CFG0 + 2 * N_CH;

   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_dw
      $error("pwm_trig_gen: DATA_W must be a multiple of 8");
   end
   if (CNT_W > DATA_W || CNT_W < 4) begin : g_bad_cw
      $error("pwm_trig_gen: CNT_W must lie in 4..DATA_W");
   end
   if (N_CH < 1) begin : g_bad_ch
      $error("pwm_trig_gen: N_CH must be at least 1");
   end
   if (N_REGS > (1 << ADDR_W)) begin : g_bad_aw
      $error("pwm_trig_gen: ADDR_W too small for the register set");
   end
   if (DEF_PERIOD < 2 || DEF_PERIOD >= (1 << CNT_W)) begin : g_bad_per
      $error("pwm_trig_gen: DEF_PERIOD out of range");
   end

   logic                       run_q;
   logic [CNT_W-1:0]           period_q;
   chan_cfg_t [N_CH-1:0]       cfg_q;
   logic [N_CH-1:0][CNT_W-1:0] cmp_wr_q;
   logic [N_CH-1:0][CNT_W-1:0] cmp_act_q;
   logic [N_CH-1:0]            cmp_we;
   logic [CNT_W-1:0]           cmp_wdata;
   logic [CNT_W-1:0]           cnt_q;
   logic                       up_q;
   logic                       first_q;
   logic                       at_peak;
   logic                       at_bottom;
   logic                       active;

   ptg_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .N_CH(N_CH),
      .ADDR_W(ADDR_W), .DEF_PERIOD(DEF_PERIOD)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .run_o(run_q), .period_o(period_q), .cfg_o(cfg_q),
      .cmp_wr_o(cmp_wr_q), .cmp_we_o(cmp_we), .cmp_wdata_o(cmp_wdata)
   );

   ptg_carrier #(.CNT_W(CNT_W)) u_carrier (
      .clk(clk), .rst_n(rst_n),
      .run_i(run_q), .period_i(period_q),
      .cnt_o(cnt_q), .up_o(up_q), .first_o(first_q),
      .peak_o(at_peak), .bottom_o(at_bottom)
   );

   assign active = run_q && !first_q;

   for (genvar i = 0; i < N_CH; i++) begin : g_chan
      ptg_channel #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .cfg_i(cfg_q[i]),
         .cmp_we_i(cmp_we[i]), .cmp_wdata_i(cmp_wdata), .cmp_buf_i(cmp_wr_q[i]),
         .cnt_i(cnt_q), .up_i(up_q), .active_i(active),
         .peak_i(at_peak), .bottom_i(at_bottom),
         .cmp_act_o(cmp_act_q[i]), .trig_o(trig_o[i])
      );
   end

endmodule

// File: rtl/pwm_trig_gen_chk.sv
module pwm_trig_gen_chk
   import ptg_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int N_CH   = 2,
   parameter int ADDR_W = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [ADDR_W-1:0]          wr_addr,
   input logic [DATA_W-1:0]          wr_data,
   input logic [DATA_W/8-1:0]        wr_be,
   input logic                       run,
   input logic [CNT_W-1:0]           cnt,
   input logic                       up,
   input logic [CNT_W-1:0]           period,
   input chan_cfg_t [N_CH-1:0]       cfg,
   input logic [N_CH-1:0][CNT_W-1:0] cmp_wr,
   input logic [N_CH-1:0][CNT_W-1:0] cmp_act,
   input logic [N_CH-1:0]            trig
);

   localparam int CMP_BASE = ADDR_CFG0 + N_CH;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assert_hold_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == ONE);

   assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run) && run |-> (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE));

   assert_quiet_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> trig == '0);

   assert_quiet_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> trig == '0);

   for (genvar i = 0; i < N_CH; i++) begin : g_chk
      assert_peak_R4: assert property (@(posedge clk) disable iff (!rst_n)
         trig[i] && cfg[i].mode == TM_PEAK |-> cnt == period);

      assert_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
         trig[i] && cfg[i].mode == TM_VALLEY |-> cnt == ONE);

      assert_up_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
         trig[i] && cfg[i].mode == TM_UP |-> cnt == cmp_act[i] && up);

      assert_down_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
         trig[i] && cfg[i].mode == TM_DOWN |-> cnt == cmp_act[i] && !up);

      assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && (&wr_be) && int'(wr_addr) == CMP_BASE + i && cfg[i].bypass
         |=> cmp_act[i] == $past(wr_data[CNT_W-1:0]));

      assert_partial_R10: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && !(&wr_be) |=> $stable(cmp_wr[i]));

      assert_hold_sched_R8: assert property (@(posedge clk) disable iff (!rst_n)
         cfg[i].mode == TM_DOWN && !cfg[i].bypass && cnt != period
         |=> $stable(cmp_act[i]));
   end

endmodule

bind pwm_trig_gen pwm_trig_gen_chk #(
   .DATA_W(DATA_W), .CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
   .run(run_q), .cnt(cnt_q), .up(up_q), .period(period_q),
   .cfg(cfg_q), .cmp_wr(cmp_wr_q), .cmp_act(cmp_act_q), .trig(trig_o)
);

// File: tb/pwm_trig_gen_test.sv
module pwm_trig_gen_test;

   localparam int A_CTRL = 0, A_PER = 1, A_CFG0 = 2, A_CFG1 = 3, A_CMP0 = 4, A_CMP1 = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  wr_be = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic [1:0]  trig;

   int checks = 0, fails = 0, cyc = 0, base = 0;
   int q0[$];
   int q1[$];
   string cur_req = "R11";
   bit done = 0;

   pwm_trig_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr),
      .rd_data(rd_data), .trig_o(trig)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d, input logic [1:0] be = 2'b11);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d); wr_be = be;
      @(negedge clk);
      wr_en = 1'b0; wr_be = '0;
   endtask

   task automatic rd_check(input string req, input int a, input int exp);
      rd_addr = 3'(a);
      #1;
      check(req, $sformatf("read addr %0d", a), int'(rd_data), exp);
   endtask

   task automatic wait_n(input int n);
      while (cyc != base + n) @(negedge clk);
   endtask

   task automatic start_run();
      base = cyc + 1;
      wr(A_CTRL, 1);
   endtask

   task automatic stop_and_drain(input string req);
      wr(A_CTRL, 0);
      repeat (3) @(negedge clk);
      check(req, "ch0 pending triggers", q0.size(), 0);
      check(req, "ch1 pending triggers", q1.size(), 0);
      q0.delete(); q1.delete();
   endtask

   // Carrier timeline from R1/R2; modes from R3/R4; first cycle quiet from R5.
   function automatic bit exp_trig(input int mode, input int c, input int p, input int n);
      int r, v;
      bit u;
      if (n == 0) return 1'b0;
      r = n % (2 * p - 2);
      if (r <= p - 1) begin v = r + 1; u = (r != 0); end
      else begin v = 2 * p - 1 - r; u = 1'b0; end
      case (mode)
         1: return (v == c) && !u;
         2: return (v == c) && u;
         3: return v == c;
         4: return v == p;
         5: return v == 1;
         6: return (v == p) || (v == 1);
         default: return 1'b0;
      endcase
   endfunction

   task automatic push_model(input int ch, input int mode, input int c, input int p, input int nmax);
      for (int n = 1; n <= nmax; n++)
         if (exp_trig(mode, c, p, n)) begin
            if (ch == 0) q0.push_back(base + n); else q1.push_back(base + n);
         end
   endtask

   task automatic setup_ch(input int ch, input int cmp, input int cfg);
      wr(ch == 0 ? A_CFG0 : A_CFG1, 0);
      wr(ch == 0 ? A_CMP0 : A_CMP1, cmp);
      wr(ch == 0 ? A_CFG0 : A_CFG1, cfg);
   endtask

   // Monitor: pops expected trigger cycles as the design produces pulses.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (trig[0]) begin
            if (q0.size() == 0) check(cur_req, "unexpected ch0 trigger at cycle", cyc, -1);
            else check(cur_req, "ch0 trigger cycle", cyc, q0.pop_front());
         end
         if (trig[1]) begin
            if (q1.size() == 0) check(cur_req, "unexpected ch1 trigger at cycle", cyc, -1);
            else check(cur_req, "ch1 trigger cycle", cyc, q1.pop_front());
         end
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      rd_check("R11", A_PER, 100);
      rd_check("R11", A_CTRL, 0);
      rd_check("R11", A_CFG0, 0);
      rd_check("R11", A_CMP1, 0);
      check("R11", "trigger in reset", int'(trig), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11", "trigger after reset", int'(trig), 0);

      // R1 R2 R3: slope matches, period 6
      cur_req = "R3";
      wr(A_PER, 6);
      setup_ch(0, 2, 1);
      setup_ch(1, 4, 2);
      start_run();
      push_model(0, 1, 2, 6, 30);
      push_model(1, 2, 4, 6, 30);
      wait_n(30);
      stop_and_drain("R1");

      // R4: peak and bottom, period 5
      cur_req = "R4";
      wr(A_PER, 5);
      wr(A_CFG0, 4);
      wr(A_CFG1, 5);
      start_run();
      push_model(0, 4, 0, 5, 20);
      push_model(1, 5, 0, 5, 20);
      wait_n(20);
      stop_and_drain("R4");

      // R3 R4: both directions and both points, period 4
      cur_req = "R3";
      wr(A_PER, 4);
      setup_ch(0, 3, 3);
      wr(A_CFG1, 6);
      start_run();
      push_model(0, 3, 3, 4, 15);
      push_model(1, 6, 0, 4, 15);
      wait_n(15);
      stop_and_drain("R3");

      // R5: compare value 1, no pulse in first cycle
      cur_req = "R5";
      wr(A_PER, 6);
      setup_ch(0, 1, 1);
      setup_ch(1, 1, 2);
      start_run();
      push_model(0, 1, 1, 6, 22);
      push_model(1, 2, 1, 6, 22);
      wait_n(22);
      stop_and_drain("R5");

      // R4: disabled encodings never fire
      cur_req = "R4";
      setup_ch(0, 3, 7);
      setup_ch(1, 3, 0);
      start_run();
      wait_n(14);
      stop_and_drain("R4");

      // R6 R7 R8: bottom-scheduled update vs bypass
      cur_req = "R8";
      setup_ch(0, 2, 2);
      setup_ch(1, 2, 10);
      start_run();
      q0.push_back(base + 1); q0.push_back(base + 13); q0.push_back(base + 23);
      q1.push_back(base + 1); q1.push_back(base + 3);
      q1.push_back(base + 13); q1.push_back(base + 23);
      wait_n(1);
      wr(A_CMP0, 4);
      cur_req = "R7";
      wr(A_CMP1, 4);
      rd_check("R6", A_CMP0, 4);
      rd_check("R6", A_CMP1, 4);
      wait_n(27);
      stop_and_drain("R8");

      // R9 and peak-scheduled update (R8)
      cur_req = "R9";
      setup_ch(0, 2, 2);
      setup_ch(1, 2, 1);
      start_run();
      q0.push_back(base + 1); q0.push_back(base + 13); q0.push_back(base + 23);
      q1.push_back(base + 9); q1.push_back(base + 18);
      wait_n(7);
      wr(A_CMP1, 3);
      wait_n(10);
      wr(A_CMP0, 4);
      wait_n(27);
      stop_and_drain("R9");

      // R10: partial byte writes change nothing
      cur_req = "R10";
      wr(A_CMP0, 16'h1234, 2'b01);
      wr(A_PER, 9, 2'b10);
      wr(A_CTRL, 1, 2'b01);
      rd_check("R10", A_CMP0, 4);
      rd_check("R10", A_PER, 6);
      rd_check("R10", A_CTRL, 0);
      repeat (4) @(negedge clk);
      check("R10", "trigger after ignored run write", int'(trig), 0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule